// File: doc/BRIEF.md
# Soft-Input Threshold Decoder for the (21,11) Difference-Set Cyclic Code

This block decodes one codeword of the (21,11) difference-set cyclic code from soft channel samples. It uses a posteriori threshold decoding. All 21 quantized samples are captured in one cycle into a circular register. A single shared check unit then visits one bit position per clock while the register rotates.

For the position under test, the check unit evaluates the five parity checks that are orthogonal on that bit. For each check it forms a parity bit from the hard decisions of the other four members. It also takes the smallest magnitude among those four members as the check's reliability (an add-min step). The signed reliabilities are summed into extrinsic information. The scaled channel value of the bit is added, and the result is clipped to the output width. That soft value, and its sign as the hard decision, are written into a 21-entry result register.

A word costs exactly 22 clock edges: one to capture and 21 to decide. A single-cycle completion pulse marks the end of the word. The scale applied to the channel sample is a static parameter.

Top module: `dsc_soft_decoder`

## Requirements
- R1: After reset, `busy_o`, `done_o`, every soft output and every decision bit are 0.
- R2: When `start_i` is high at a clock edge while the block is idle, the 21 samples on `samp_i` are captured at that edge and `busy_o` is high from the next cycle on. Sample k sits at bits [5k+4:5k] and is a 5-bit two's-complement value.
- R3: A `start_i` that arrives while `busy_o` is high is ignored: neither the captured samples nor the schedule change.
- R4: `done_o` is high for exactly one cycle, following the 21st edge after the capturing edge. `busy_o` falls at that same edge.
- R5: Positions are decided in descending order. Position 20 is written at the first edge after capture, and position 0 is written at the 21st.
- R6: For position j, check i (i = 0..4) covers bits (j + d_k − d_i) mod 21 for every k ≠ i, where d = {0, 1, 4, 14, 16}.
- R7: For each check, the parity term is the XOR of the members' hard decisions (1 for a negative sample). The reliability is the minimum member magnitude; the magnitude of −16 is 16.
- R8: The soft output of position j is SCALE·y_j plus the sum over the checks of (reliability if parity is 0, minus reliability if parity is 1). It saturates to the signed OUT_W range, which is [−64, 63] at the defaults SCALE = 2 and OUT_W = 7. Position j appears at `llr_o` bits [7j+6:7j].
- R9: Decision bit j is 1 exactly when soft output j is negative.
- R10: Between words, the soft outputs and decisions keep their last values until a new word overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture samples and begin a word when idle |
| samp_i | input | 105 | 21 packed 5-bit two's-complement samples |
| busy_o | output | 1 | Word in progress |
| done_o | output | 1 | One-cycle end-of-word pulse |
| llr_o | output | 147 | 21 packed signed soft outputs (OUT_W bits each) |
| dec_o | output | 21 | Hard decisions, 1 = negative soft output |

## Verification
A wrong peer offset or a wrong rotation direction corrupts soft values at the affected positions. Because the positions are written one per cycle in descending order, the bench checks position 20 one edge after capture and the full vector at the pulse. A fault in the schedule counter shifts the completion pulse, or leaves a position unwritten, and shows within the 22-cycle window. Add-min or saturation faults show on any word with mixed signs or with uniformly strong samples, both of which the stimulus includes.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
    localparam int CW_N  = 21;
    localparam int CHK_J = 5;
    localparam int DSET [CHK_J] = '{0, 1, 4, 14, 16};

    // Ring slot holding member m of check i when the bit under test sits in the top slot.
    function automatic int peer_slot(input int i, input int m);
        int k;
        k = (m < i) ? m : m + 1;
        return (2 * CW_N - 1 + DSET[k] - DSET[i]) % CW_N;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/tsd_addmin.sv
module tsd_addmin #(
    parameter int NPORT = 4,
    parameter int W     = 5
) (
    input  logic [NPORT-1:0][W-1:0] val_i,
    output logic                    par_o,
    output logic [W-1:0]            mag_o
);
    function automatic logic [W-1:0] absu(input logic [W-1:0] v);
        return v[W-1] ? (~v + 1'b1) : v;
    endfunction

    always_comb begin
        par_o = 1'b0;
        mag_o = '1;
        for (int p = 0; p < NPORT; p++) begin
            par_o = par_o ^ val_i[p][W-1];
            if (absu(val_i[p]) < mag_o) mag_o = absu(val_i[p]);
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            AST_MIN_BELOW_ALL: assert (mag_o <= absu(val_i[p])) else $error("min above member"); // R7
        end
    end
endmodule

// File: rtl/tsd_combine.sv
module tsd_combine #(
    parameter int NTERM = 5,
    parameter int MW    = 5,
    parameter int CW    = 7,
    parameter int OW    = 7
) (
    input  logic [NTERM-1:0]         par_i,
    input  logic [NTERM-1:0][MW-1:0] mag_i,
    input  logic signed [CW-1:0]     chan_i,
    output logic signed [OW-1:0]     llr_o
);
    localparam int BASE_W = (CW > MW + 1) ? CW : MW + 1;
    localparam int AW     = ((BASE_W > OW) ? BASE_W : OW) + $clog2(NTERM + 1) + 1;
    localparam int HI_I   = (1 << (OW - 1)) - 1;
    localparam int LO_I   = -(1 << (OW - 1));

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] term;

    always_comb begin
        acc = AW'(chan_i);
        for (int t = 0; t < NTERM; t++) begin
            term = AW'(mag_i[t]);
            acc  = par_i[t] ? acc - term : acc + term;
        end
        if (acc > $signed(AW'(HI_I)))      llr_o = OW'(HI_I);
        else if (acc < $signed(AW'(LO_I))) llr_o = OW'(LO_I);
        else                               llr_o = acc[OW-1:0];
    end
endmodule

// File: rtl/dsc_soft_decoder.sv
module dsc_soft_decoder
    import tsd_pkg::*;
#(
    parameter int Q_W   = 5,
    parameter int OUT_W = 7,
    parameter int SCALE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CW_N*Q_W-1:0]      samp_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [CW_N*OUT_W-1:0]    llr_o,
    output logic [CW_N-1:0]          dec_o
);
    localparam int CNT_W = $clog2(CW_N);
    localparam int CH_W  = Q_W + $clog2(SCALE) + 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CW_N - 1);

    typedef struct packed {
        logic                          run;
        logic [CNT_W-1:0]              cnt;
        logic [CW_N-1:0][Q_W-1:0]      ring;
        logic [CW_N-1:0][OUT_W-1:0]    llr;
        logic [CW_N-1:0]               dec;
        logic                          done;
    } st_t;

    st_t s_d, s_q;

    logic [CHK_J-1:0]            par_w;
    logic [CHK_J-1:0][Q_W-1:0]   mag_w;
    logic signed [CH_W-1:0]      chan_w;
    logic signed [OUT_W-1:0]     llr_w;
    logic [CNT_W-1:0]            pos_w;

    // One add-min unit per orthogonal check, fed from fixed ring slots.
    for (genvar i = 0; i < CHK_J; i++) begin : g_chk
        logic [CHK_J-2:0][Q_W-1:0] grp;
        for (genvar m = 0; m < CHK_J - 1; m++) begin : g_mem
            assign grp[m] = s_q.ring[peer_slot(i, m)];
        end
        tsd_addmin #(.NPORT(CHK_J - 1), .W(Q_W)) u_am (
            .val_i (grp),
            .par_o (par_w[i]),
            .mag_o (mag_w[i])
        );
    end

    // Channel term: shift for a power-of-two scale, multiply otherwise.
    logic signed [CH_W-1:0] y_ext;
    assign y_ext = CH_W'($signed(s_q.ring[CW_N-1]));
    if (is_pow2(SCALE)) begin : g_shift
        assign chan_w = y_ext <<< $clog2(SCALE);
    end else begin : g_mult
        assign chan_w = y_ext * $signed(CH_W'(SCALE));
    end

    tsd_combine #(.NTERM(CHK_J), .MW(Q_W), .CW(CH_W), .OW(OUT_W)) u_sum (
        .par_i  (par_w),
        .mag_i  (mag_w),
        .chan_i (chan_w),
        .llr_o  (llr_w)
    );

    assign pos_w = LAST - s_q.cnt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.run) begin
            if (start_i) begin
                s_d.ring = samp_i;
                s_d.run  = 1'b1;
                s_d.cnt  = '0;
            end
        end else begin
            s_d.llr[pos_w] = llr_w;
            s_d.dec[pos_w] = llr_w[OUT_W-1];
            s_d.ring       = {s_q.ring[CW_N-2:0], s_q.ring[CW_N-1]};
            if (s_q.cnt == LAST) begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.run;
    assign done_o = s_q.done;
    assign llr_o  = s_q.llr;
    assign dec_o  = s_q.dec;

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R2
    AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.cnt != LAST) |=> (s_q.run && s_q.cnt == $past(s_q.cnt) + 1'b1)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(s_q.run) && $past(s_q.cnt) == LAST && !busy_o)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(llr_o) && $stable(dec_o))); // R10
endmodule

// File: tb/sim_dsc_soft_decoder.sv
module sim_dsc_soft_decoder;
    localparam int N = 21;
    localparam int QW = 5;
    localparam int OW = 7;
    localparam int SC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [N*QW-1:0] samp_i = '0;
    logic busy_o, done_o;
    logic [N*OW-1:0] llr_o;
    logic [N-1:0] dec_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dsc_soft_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .samp_i(samp_i),
        .busy_o(busy_o), .done_o(done_o), .llr_o(llr_o), .dec_o(dec_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_llr(input int y [N], input int j);
        int ds [5] = '{0, 1, 4, 14, 16};
        int w = 0;
        int t;
        for (int i = 0; i < 5; i++) begin
            int par = 0;
            int mn = 1000;
            for (int k = 0; k < 5; k++) begin
                if (k != i) begin
                    int v = y[(j + ds[k] - ds[i] + 2 * N) % N];
                    int a = (v < 0) ? -v : v;
                    if (v < 0) par ^= 1;
                    if (a < mn) mn = a;
                end
            end
            w += par ? -mn : mn;
        end
        t = SC * y[j] + w;
        if (t > 63) t = 63;
        if (t < -64) t = -64;
        return t;
    endfunction

    function automatic int got_llr(input int j);
        return int'($signed(llr_o[j*OW +: OW]));
    endfunction

    task automatic load_bus(input int y [N]);
        for (int k = 0; k < N; k++) samp_i[k*QW +: QW] = QW'(y[k]);
    endtask

    task automatic run_word(input int y [N], input bit intrude);
        int junk [N];
        int e;
        @(negedge clk);
        load_bus(y);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        @(negedge clk);
        e = ref_llr(y, N - 1);
        chk(got_llr(N - 1) == e, "R5 position 20 first", got_llr(N - 1), e);
        if (intrude) begin
            for (int k = 0; k < N; k++) junk[k] = -y[k] - 1;
            load_bus(junk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (19) @(negedge clk);
        end else begin
            repeat (20) @(negedge clk);
        end
        chk(done_o == 1'b1, "R4 done at edge 21", done_o, 1);
        chk(busy_o == 1'b0, "R4 busy falls", busy_o, 0);
        for (int j = 0; j < N; j++) begin
            e = ref_llr(y, j);
            chk(got_llr(j) == e, intrude ? "R3 start ignored" : "R6 R7 R8 soft output", got_llr(j), e);
            chk(dec_o[j] == (e < 0), "R9 decision", dec_o[j], (e < 0));
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R4 single pulse", done_o, 0);
        repeat (3) @(negedge clk);
        for (int j = 0; j < N; j++) begin
            e = ref_llr(y, j);
            chk(got_llr(j) == e, "R10 hold between words", got_llr(j), e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int y [N];
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
        chk(done_o == 1'b0, "R1 done reset", done_o, 0);
        chk(llr_o == '0, "R1 llr reset", 0, 0);
        chk(dec_o == '0, "R1 dec reset", int'(dec_o), 0);
        rst_n = 1'b1;

        // Strong positive word: saturates high.
        for (int k = 0; k < N; k++) y[k] = 15;
        run_word(y, 1'b0);
        // All -16: magnitude 16 and saturation corner.
        for (int k = 0; k < N; k++) y[k] = -16;
        run_word(y, 1'b0);
        // Mostly confident zeros with one flipped weak bit.
        for (int k = 0; k < N; k++) y[k] = 9;
        y[7] = -3;
        run_word(y, 1'b0);
        // All zero samples.
        for (int k = 0; k < N; k++) y[k] = 0;
        run_word(y, 1'b0);
        // Start during a word must be ignored.
        for (int k = 0; k < N; k++) y[k] = int'($urandom_range(31)) - 16;
        run_word(y, 1'b1);
        // Random words, some noisy, some biased.
        for (int r = 0; r < 12; r++) begin
            for (int k = 0; k < N; k++) begin
                if (r % 2 == 0) y[k] = int'($urandom_range(31)) - 16;
                else y[k] = ($urandom_range(7) == 0) ? -int'($urandom_range(8)) : int'($urandom_range(15));
            end
            run_word(y, 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule